// File: doc/BRIEF.md
# Bit-Serial Maximum Selector

This block takes two unsigned words that arrive one bit per clock, most significant bit first, and streams out the larger of the two in the same bit-serial order. A word-start strobe travels with the first (most significant) bit of each word. Because the larger operand is known at the first bit position where the two streams differ, the output does not wait for the whole word: in the plain variant each output bit leaves one clock after the matching input bit. This makes the unit a building block for chained maximum trees in pipelines that process pixels one bit at a time.

A parameter selects a non-zero variant. In that variant an operand whose every bit is zero counts as absent, so the other operand is passed through unchanged. If both are zero, the output is zero. To know that a word is all zero before its first output bit leaves, both streams go through a delay line one word long while an OR accumulator inspects them. The result then steers the first output bit. This costs one word of extra latency.

Words may follow each other back to back or with idle cycles between them. Input bits outside a word have no effect. The word length is a parameter.

Top module: `bitser_max`

## Requirements
- R1: In plain mode (`NONZERO`=0) the `WORD_W`-bit word that leaves on `y_o`, first bit most significant, equals the unsigned maximum of the two words applied on `a_i` and `b_i`. The word's first bit is the cycle in which `start_i` is 1.
- R2: In plain mode `y_start_o` is 1 exactly one clock after `start_i` was 1, and `y_o` carries the most significant result bit in that same cycle.
- R3: Two equal operand words produce that same word on the output.
- R4: The decision is taken at the first differing bit and kept for the rest of the word. After it, the output follows the larger operand bit for bit, including its zero bits (for example, 0x8000 against 0x7FFF gives 0x8000).
- R5: Each `start_i` discards the previous word's decision. Two back-to-back words in which the larger side swaps are each resolved on their own.
- R6: In non-zero mode (`NONZERO`=1), when one operand word is all zero and the other is not, the output word equals the non-zero operand.
- R7: In non-zero mode, two all-zero operand words give an all-zero output word.
- R8: In non-zero mode `y_start_o` rises `WORD_W`+1 clocks after `start_i`, together with the most significant result bit.
- R9: Starts may be spaced more than `WORD_W` cycles apart. Bits on `a_i` and `b_i` in cycles outside a word do not change any result, and output word strobes are at least `WORD_W` cycles apart.
- R10: While `rst_n` is low and right after it, `y_o` and `y_start_o` are 0.
- R11: `WORD_W` sets the number of bits per word. A 10-bit instance gives correct 10-bit results under both the zero and the non-zero operand cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | High with the most significant bit of each operand pair |
| a_i | input | 1 | First operand, one bit per clock, MSB first |
| b_i | input | 1 | Second operand, one bit per clock, MSB first |
| y_o | output | 1 | Maximum, one bit per clock, MSB first |
| y_start_o | output | 1 | High with the most significant bit of each result word |

## Verification
The case that is hardest to reach is a decision taken and then overturned by the next word's strobe with no idle cycle in between. The opposite case is a word whose only difference lies in the least significant bit, so the state machine stays undecided to the very end. Directed back-to-back pairs with a swapped larger side and single-bit differences cover these. Random words with random idle gaps filled with junk bits exercise the strobe-driven restart and the gap immunity. In the non-zero instance, about a quarter of the random operands are forced to zero, so the look-ahead path and the both-zero case come up often while the delayed words overlap the next incoming word.

// File: rtl/bitser_max_pkg.sv
package bitser_max_pkg;

  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_A    = 2'd1,
    DEC_B    = 2'd2
  } dec_t;

  // Next decision state from the current one and the bits seen this cycle.
  function automatic dec_t dec_step(input dec_t cur, input logic a, input logic b);
    dec_t r;
    r = cur;
    if (cur == DEC_NONE && a != b) r = a ? DEC_A : DEC_B;
    return r;
  endfunction

  // Output bit for the current decision state.
  function automatic logic dec_pick(input dec_t cur, input logic a, input logic b);
    logic r;
    case (cur)
      DEC_A:   r = a;
      DEC_B:   r = b;
      default: r = a | b;
    endcase
    return r;
  endfunction

  // Initial decision forced by the zero look-ahead.
  function automatic dec_t nz_force(input logic a_zero, input logic b_zero);
    dec_t r;
    r = DEC_NONE;
    if (a_zero && !b_zero) r = DEC_B;
    else if (b_zero && !a_zero) r = DEC_A;
    return r;
  endfunction

endpackage

// File: rtl/bitser_max_core.sv
module bitser_max_core
  import bitser_max_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic a_i,
  input  logic b_i,
  input  dec_t force_i,
  output logic y_o,
  output logic y_start_o
);

  dec_t dec_q;
  dec_t dec_eff;
  dec_t dec_nxt;
  logic pick_bit;

  always_comb begin
    dec_eff  = start_i ? force_i : dec_q;
    dec_nxt  = dec_step(dec_eff, a_i, b_i);
    pick_bit = dec_pick(dec_eff, a_i, b_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q     <= DEC_NONE;
      y_o       <= 1'b0;
      y_start_o <= 1'b0;
    end else begin
      dec_q     <= dec_nxt;
      y_o       <= pick_bit;
      y_start_o <= start_i;
    end
  end

  // R4
  decision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q != DEC_NONE && !start_i) |=> (dec_q == $past(dec_q)));

  // R4
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_q != 2'b11);

  // R1
  undecided_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && dec_q == DEC_NONE) |=> (y_o == ($past(a_i) | $past(b_i))));

  // R4
  follow_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && dec_q == DEC_A) |=> (y_o == $past(a_i)));

  // R2
  strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> y_start_o);

endmodule

// File: rtl/bitser_max_dline.sv
module bitser_max_dline #(
  parameter int DEPTH = 16,
  parameter int DW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/bitser_max_zdet.sv
module bitser_max_zdet (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic a_i,
  input  logic b_i,
  output logic a_zero_o,
  output logic b_zero_o
);

  logic any_a_q;
  logic any_b_q;

  // Restarted by each strobe; one word later it holds the OR of that word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_a_q <= 1'b0;
      any_b_q <= 1'b0;
    end else begin
      any_a_q <= start_i ? a_i : (any_a_q | a_i);
      any_b_q <= start_i ? b_i : (any_b_q | b_i);
    end
  end

  assign a_zero_o = ~any_a_q;
  assign b_zero_o = ~any_b_q;

endmodule

// File: rtl/bitser_max.sv
module bitser_max
  import bitser_max_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter bit NONZERO = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic a_i,
  input  logic b_i,
  output logic y_o,
  output logic y_start_o
);

  localparam int DW    = 3;
  localparam int GAP_W = $clog2(WORD_W + 1);

  if (NONZERO) begin : g_nz
    logic [DW-1:0] dly_bus;
    logic dly_start, a_d, b_d;
    logic a_zero, b_zero;
    dec_t force_dec;

    bitser_max_dline #(.DEPTH(WORD_W), .DW(DW)) u_dline (
      .clk(clk), .rst_n(rst_n),
      .d_i({start_i, a_i, b_i}),
      .q_o(dly_bus)
    );

    assign {dly_start, a_d, b_d} = dly_bus;

    bitser_max_zdet u_zdet (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .a_i(a_i), .b_i(b_i),
      .a_zero_o(a_zero), .b_zero_o(b_zero)
    );

    assign force_dec = nz_force(a_zero, b_zero);

    bitser_max_core u_core (
      .clk(clk), .rst_n(rst_n), .start_i(dly_start),
      .a_i(a_d), .b_i(b_d), .force_i(force_dec),
      .y_o(y_o), .y_start_o(y_start_o)
    );

    // R6
    nz_pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_start && a_zero && !b_zero) |=> (y_o == $past(b_d)));

    // R6
    nz_pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_start && b_zero && !a_zero) |=> (y_o == $past(a_d)));

    // R7
    nz_both_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_start && a_zero && b_zero) |=> !y_o);
  end else begin : g_plain
    bitser_max_core u_core (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .a_i(a_i), .b_i(b_i), .force_i(DEC_NONE),
      .y_o(y_o), .y_start_o(y_start_o)
    );
  end

  // Cycles since the last output strobe, saturating at the word length.
  logic [GAP_W-1:0] out_gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             out_gap_q <= GAP_W'(WORD_W);
    else if (y_start_o)                     out_gap_q <= GAP_W'(1);
    else if (out_gap_q < GAP_W'(WORD_W))    out_gap_q <= out_gap_q + GAP_W'(1);
  end

  // R9
  out_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_start_o |-> (out_gap_q == GAP_W'(WORD_W)));

endmodule

// File: tb/sim_bitser_max.sv
`timescale 1ns/1ps
module sim_bitser_max;

  localparam int W0 = 16;
  localparam int W1 = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0 = 0, a0 = 0, b0 = 0;
  logic s1 = 0, a1 = 0, b1 = 0;
  logic y0, ys0, y1, ys1;

  always #2 clk = ~clk;

  bitser_max #(.WORD_W(W0), .NONZERO(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(s0), .a_i(a0), .b_i(b0),
    .y_o(y0), .y_start_o(ys0));

  bitser_max #(.WORD_W(W1), .NONZERO(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(s1), .a_i(a1), .b_i(b1),
    .y_o(y1), .y_start_o(ys1));

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] exp_q0[$], exp_q1[$];
  int cyc_q0[$], cyc_q1[$];
  string tag_q0[$], tag_q1[$];

  function automatic logic [15:0] ref_max(logic [15:0] a, logic [15:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [15:0] ref_nzmax(logic [15:0] a, logic [15:0] b);
    if (a == 0) return b;
    if (b == 0) return a;
    return (a > b) ? a : b;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Serialize one operand pair onto instance sel, then idle cycles with junk bits.
  task automatic send(int sel, logic [15:0] a, logic [15:0] b, int gap, string tag);
    int w;
    w = (sel == 0) ? W0 : W1;
    for (int i = w - 1; i >= 0; i--) begin
      @(negedge clk);
      if (sel == 0) begin
        s0 = (i == w - 1); a0 = a[i]; b0 = b[i];
        if (i == w - 1) begin
          exp_q0.push_back(ref_max(a, b)); cyc_q0.push_back(cyc); tag_q0.push_back(tag);
        end
      end else begin
        s1 = (i == w - 1); a1 = a[i]; b1 = b[i];
        if (i == w - 1) begin
          exp_q1.push_back(ref_nzmax(a & 16'h3FF, b & 16'h3FF));
          cyc_q1.push_back(cyc); tag_q1.push_back(tag);
        end
      end
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (sel == 0) begin s0 = 0; a0 = 1'($urandom); b0 = 1'($urandom); end
      else          begin s1 = 0; a1 = 1'($urandom); b1 = 1'($urandom); end
    end
  endtask

  // Collect output words from u0.
  int cnt0 = 0; bit col0 = 0; logic [15:0] acc0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ys0) begin
        col0 = 1; cnt0 = 1; acc0 = 16'(y0);
        if (cyc_q0.size() == 0) check("R2 unexpected strobe", 1, 0);
        else check("R2 latency", 32'(cyc - cyc_q0.pop_front()), 32'd1);
      end else if (col0) begin
        acc0 = {acc0[14:0], y0}; cnt0++;
      end
      if (col0 && cnt0 == W0) begin
        col0 = 0;
        if (exp_q0.size() == 0) check("R1 no expected word", 1, 0);
        else check(tag_q0.pop_front(), 32'(acc0), 32'(exp_q0.pop_front()));
      end
    end
  end

  // Collect output words from u1.
  int cnt1 = 0; bit col1 = 0; logic [15:0] acc1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ys1) begin
        col1 = 1; cnt1 = 1; acc1 = 16'(y1);
        if (cyc_q1.size() == 0) check("R8 unexpected strobe", 1, 0);
        else check("R8 latency", 32'(cyc - cyc_q1.pop_front()), 32'(W1 + 1));
      end else if (col1) begin
        acc1 = {acc1[14:0], y1}; cnt1++;
      end
      if (col1 && cnt1 == W1) begin
        col1 = 0;
        if (exp_q1.size() == 0) check("R11 no expected word", 1, 0);
        else check(tag_q1.pop_front(), 32'(acc1), 32'(exp_q1.pop_front()));
      end
    end
  end

  initial begin
    logic [15:0] ra, rb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 during reset
    check("R10 y0 in reset", 32'(y0), 0);
    check("R10 ys0 in reset", 32'(ys0), 0);
    check("R10 y1 in reset", 32'(y1), 0);
    check("R10 ys1 in reset", 32'(ys1), 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 ys0 after reset", 32'(ys0), 0);
    check("R10 ys1 after reset", 32'(ys1), 0);

    // Plain instance: directed corners
    send(0, 16'hA5A5, 16'hA5A5, 0, "R3 equal");
    send(0, 16'hFFFF, 16'hFFFF, 0, "R3 all ones");
    send(0, 16'h8000, 16'h7FFF, 0, "R4 msb diff");
    send(0, 16'h7FFF, 16'h8000, 0, "R4 msb diff b");
    send(0, 16'h1234, 16'h1235, 0, "R4 lsb diff");
    send(0, 16'h0000, 16'h0001, 0, "R1 zero vs one");
    send(0, 16'h0000, 16'h0000, 0, "R1 both zero");
    send(0, 16'hF000, 16'h0FFF, 0, "R5 a larger");
    send(0, 16'h0FFF, 16'hF000, 0, "R5 b larger");
    send(0, 16'hC000, 16'h4000, 5, "R9 gap junk");
    send(0, 16'h00FF, 16'h00F0, 3, "R9 gap junk 2");
    for (int k = 0; k < 200; k++) begin
      ra = 16'($urandom); rb = (k % 5 == 0) ? ra ^ 16'(1 << ($urandom % 16)) : 16'($urandom);
      send(0, ra, rb, int'($urandom % 3), "R1 random");
    end
    repeat (W0 + 4) @(negedge clk);
    s0 = 0; a0 = 0; b0 = 0;

    // Non-zero instance: directed corners
    send(1, 16'h000, 16'h2AB, 0, "R6 a zero");
    send(1, 16'h3FF, 16'h000, 0, "R6 b zero");
    send(1, 16'h000, 16'h000, 0, "R7 both zero");
    send(1, 16'h000, 16'h001, 0, "R6 a zero b one");
    send(1, 16'h155, 16'h155, 0, "R3 nz equal");
    send(1, 16'h200, 16'h1FF, 0, "R11 msb diff");
    send(1, 16'h1FF, 16'h200, 2, "R9 nz gap");
    send(1, 16'h000, 16'h000, 4, "R7 both zero gap");
    for (int k = 0; k < 200; k++) begin
      ra = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom) & 16'h3FF;
      rb = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom) & 16'h3FF;
      send(1, ra, rb, int'($urandom % 3), "R11 nz random");
    end
    @(negedge clk); s1 = 0; a1 = 0; b1 = 0;
    repeat (W1 + 6) @(negedge clk);

    check("R1 all words out", 32'(exp_q0.size()), 0);
    check("R8 all words out", 32'(exp_q1.size()), 0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule